// File: doc/BRIEF.md
# IOMMU Control and Interrupt Register Block

This block is the software-facing front of a paging I/O memory management unit. It decodes 32-bit register reads and writes on a simple request port and holds the base address of the page directory. It runs write-only commands that switch translation on and off, enter and leave a stall, flush the translation cache, finish a page fault and force a reset. The page walker and the translation cache sit outside the block. The block drives their control lines and takes their fault and bus-error events back.

Interrupts are kept as a raw pair: bit 0 is a page fault and bit 1 is a bus read error. Each raw bit has an enable in a mask register. Software clears a bit by writing a 1 to it. The interrupt line is the OR of the raw bits that are enabled. A read returns its data on the clock after the request.

Top module: `mmu_ctl_regs`

## Requirements
- R1: A write to the directory base register (offset 0x00) keeps bits 31:12 and forces bits 11:0 to zero. Writing 0xCAFEBABE reads back 0xCAFEB000, and `dir_base` shows the same value.
- R2: Command 0, written to offset 0x08 (bits 2:0), turns translation on. Command 1 turns it off. Status (offset 0x04) bit 0 and `xlate_en` follow.
- R3: Command 2 sets the stall only while translation is on. Otherwise it has no effect. Status bit 2 and `xlate_hold` show the stall, and status bit 31 is the inverse of bit 2.
- R4: Command 3 clears the stall and leaves translation in its current state, so translation resumes.
- R5: Command 4 raises `tlb_flush_all` for exactly one cycle, starting on the clock after the write.
- R6: A write to offset 0x10 raises `tlb_inval` for exactly one cycle, with `tlb_inval_vpn` equal to bits 31:12 of the written data.
- R7: A `walk_fault` event sets raw interrupt bit 0 and status bit 1. It captures `walk_fault_va` in the register at offset 0x0C, and `walk_fault_wr` in status bit 5. Command 5 clears status bit 1.
- R8: A `walk_bus_err` event sets raw interrupt bit 1. The raw interrupt status is at offset 0x14.
- R9: The masked status (offset 0x20) equals the raw status AND the mask (offset 0x1C, bits 1:0). `irq` is the OR of the masked bits.
- R10: Writing a 1 to a bit of the clear register (offset 0x18) clears that raw bit. Bits written as 0 are unchanged. An event in the same cycle takes priority over the clear.
- R11: Command 6 returns the base, mode, stall, fault, mask, raw status, fault address and clock-gating registers to zero.
- R12: Reads of the command register, of offset 0x10 and of unmapped offsets return zero. Status bits 3 and 4 show `walk_idle` and `replay_empty`. Bit 0 of offset 0x24 drives `clk_gate_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_valid | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid the cycle after the read |
| walk_fault | input | 1 | Page fault event from the walker |
| walk_fault_wr | input | 1 | The faulting access was a write |
| walk_fault_va | input | DATA_W | Faulting virtual address |
| walk_bus_err | input | 1 | Bus read error event |
| walk_idle | input | 1 | Walker is idle |
| replay_empty | input | 1 | Replay buffer is empty |
| xlate_en | output | 1 | Translation enabled |
| xlate_hold | output | 1 | Hold off new translations (stall) |
| dir_base | output | DATA_W | Page directory base address |
| tlb_flush_all | output | 1 | Flush-all pulse to the translation cache |
| tlb_inval | output | 1 | Single-line invalidate pulse |
| tlb_inval_vpn | output | DATA_W-PAGE_SHIFT | Page number to invalidate |
| clk_gate_en | output | 1 | Clock auto-gating enable |
| irq | output | 1 | Interrupt request |

## Verification
The interrupt path is driven by a seeded random mix of mask writes, fault and bus-error events in any combination, and partial clear writes. After each step the raw, masked and `irq` values are compared with a bench model, which separates a wrong mask AND from clear bits leaking onto neighbouring bits. Directed sequences cover the command corners: stall requested while translation is off versus on, a stall exit that must leave translation on, and a force reset after every register has been loaded with a non-zero value. Pulse outputs are checked both on the cycle after the write and on the cycle after that, which tells a one-cycle pulse apart from a level.

// File: rtl/mmu_ctl_pkg.sv
package mmu_ctl_pkg;

  localparam int OFF_DIR   = 'h00;
  localparam int OFF_STAT  = 'h04;
  localparam int OFF_CMD   = 'h08;
  localparam int OFF_FVA   = 'h0C;
  localparam int OFF_INVAL = 'h10;
  localparam int OFF_RAW   = 'h14;
  localparam int OFF_CLR   = 'h18;
  localparam int OFF_MASK  = 'h1C;
  localparam int OFF_MSK_S = 'h20;
  localparam int OFF_GATE  = 'h24;

  localparam int IRQ_W = 2;

  typedef enum logic [2:0] {
    CMD_XLATE_ON  = 3'd0,
    CMD_XLATE_OFF = 3'd1,
    CMD_STALL_ON  = 3'd2,
    CMD_STALL_OFF = 3'd3,
    CMD_FLUSH     = 3'd4,
    CMD_FAULT_END = 3'd5,
    CMD_FORCE_RST = 3'd6,
    CMD_NOP       = 3'd7
  } mmu_cmd_e;

  function automatic logic [31:0] page_align(input logic [31:0] a, input int shift);
    logic [31:0] m;
    m = '1;
    m = m << shift;
    return a & m;
  endfunction

  function automatic logic [IRQ_W-1:0] irq_gate(input logic [IRQ_W-1:0] raw,
                                                input logic [IRQ_W-1:0] msk);
    return raw & msk;
  endfunction

endpackage

// File: rtl/mmu_ctl_mode.sv
module mmu_ctl_mode
  import mmu_ctl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cmd_we,
  input  mmu_cmd_e cmd_code,
  input  logic     fault_evt,
  output logic     paging_on,
  output logic     stall_on,
  output logic     fault_active,
  output logic     flush_pulse
);

  logic force_rst;
  assign force_rst = cmd_we && (cmd_code == CMD_FORCE_RST);

  always_ff @(posedge clk) begin
    if (!rst_n || force_rst) begin
      paging_on    <= 1'b0;
      stall_on     <= 1'b0;
      fault_active <= 1'b0;
      flush_pulse  <= 1'b0;
    end else begin
      flush_pulse <= 1'b0;
      if (cmd_we) begin
        case (cmd_code)
          CMD_XLATE_ON:  paging_on <= 1'b1;
          CMD_XLATE_OFF: paging_on <= 1'b0;
          CMD_STALL_ON:  if (paging_on) stall_on <= 1'b1;
          CMD_STALL_OFF: stall_on <= 1'b0;
          CMD_FLUSH:     flush_pulse <= 1'b1;
          CMD_FAULT_END: fault_active <= 1'b0;
          default: ;
        endcase
      end
      if (fault_evt) fault_active <= 1'b1;
    end
  end

  // R3
  stall_ign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_code == CMD_STALL_ON && !paging_on) |=> (stall_on == $past(stall_on)));

  // R4
  stall_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_code == CMD_STALL_OFF) |=> (!stall_on && paging_on == $past(paging_on)));

  // R5
  flush_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_pulse |-> $past(cmd_we && cmd_code == CMD_FLUSH));

  // R7
  fault_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && cmd_code == CMD_FAULT_END && !fault_evt) |=> !fault_active);

endmodule

// File: rtl/mmu_ctl_irq.sv
module mmu_ctl_irq
  import mmu_ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             soft_clr,
  input  logic [IRQ_W-1:0] evt,
  input  logic             clr_we,
  input  logic [IRQ_W-1:0] clr_bits,
  input  logic             mask_we,
  input  logic [IRQ_W-1:0] mask_bits,
  output logic [IRQ_W-1:0] raw,
  output logic [IRQ_W-1:0] mask,
  output logic [IRQ_W-1:0] masked,
  output logic             irq
);

  always_ff @(posedge clk) begin
    if (!rst_n || soft_clr) begin
      raw  <= '0;
      mask <= '0;
    end else begin
      if (mask_we) mask <= mask_bits;
      raw <= (clr_we ? (raw & ~clr_bits) : raw) | evt;
    end
  end

  assign masked = irq_gate(raw, mask);
  assign irq    = |masked;

  // R10
  clear_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && clr_bits[0] && !evt[0]) |=> !raw[0]);

  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(evt != '0 || mask_we));

endmodule

// File: rtl/mmu_ctl_regs.sv
module mmu_ctl_regs
  import mmu_ctl_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int PAGE_SHIFT = 12
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         reg_valid,
  input  logic                         reg_write,
  input  logic [ADDR_W-1:0]            reg_addr,
  input  logic [DATA_W-1:0]            reg_wdata,
  output logic [DATA_W-1:0]            reg_rdata,
  input  logic                         walk_fault,
  input  logic                         walk_fault_wr,
  input  logic [DATA_W-1:0]            walk_fault_va,
  input  logic                         walk_bus_err,
  input  logic                         walk_idle,
  input  logic                         replay_empty,
  output logic                         xlate_en,
  output logic                         xlate_hold,
  output logic [DATA_W-1:0]            dir_base,
  output logic                         tlb_flush_all,
  output logic                         tlb_inval,
  output logic [DATA_W-PAGE_SHIFT-1:0] tlb_inval_vpn,
  output logic                         clk_gate_en,
  output logic                         irq
);

  localparam int VPN_W = DATA_W - PAGE_SHIFT;

  logic wr_en, rd_en;
  logic we_dir, we_cmd, we_inval, we_clr, we_mask, we_gate;
  logic force_rst;
  mmu_cmd_e cmd_code;

  assign wr_en    = reg_valid && reg_write;
  assign rd_en    = reg_valid && !reg_write;
  assign we_dir   = wr_en && (reg_addr == ADDR_W'(OFF_DIR));
  assign we_cmd   = wr_en && (reg_addr == ADDR_W'(OFF_CMD));
  assign we_inval = wr_en && (reg_addr == ADDR_W'(OFF_INVAL));
  assign we_clr   = wr_en && (reg_addr == ADDR_W'(OFF_CLR));
  assign we_mask  = wr_en && (reg_addr == ADDR_W'(OFF_MASK));
  assign we_gate  = wr_en && (reg_addr == ADDR_W'(OFF_GATE));
  assign cmd_code = mmu_cmd_e'(reg_wdata[2:0]);
  assign force_rst = we_cmd && (cmd_code == CMD_FORCE_RST);

  logic paging_on, stall_on, fault_active;
  logic [IRQ_W-1:0] raw, mask, masked;

  mmu_ctl_mode mode_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_we       (we_cmd),
    .cmd_code     (cmd_code),
    .fault_evt    (walk_fault),
    .paging_on    (paging_on),
    .stall_on     (stall_on),
    .fault_active (fault_active),
    .flush_pulse  (tlb_flush_all)
  );

  mmu_ctl_irq irq_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .soft_clr  (force_rst),
    .evt       ({walk_bus_err, walk_fault}),
    .clr_we    (we_clr),
    .clr_bits  (reg_wdata[IRQ_W-1:0]),
    .mask_we   (we_mask),
    .mask_bits (reg_wdata[IRQ_W-1:0]),
    .raw       (raw),
    .mask      (mask),
    .masked    (masked),
    .irq       (irq)
  );

  logic [DATA_W-1:0] fault_va;
  logic              fault_wr;

  always_ff @(posedge clk) begin
    if (!rst_n || force_rst) begin
      dir_base    <= '0;
      fault_va    <= '0;
      fault_wr    <= 1'b0;
      clk_gate_en <= 1'b0;
    end else begin
      if (we_dir)     dir_base    <= page_align(reg_wdata, PAGE_SHIFT);
      if (we_gate)    clk_gate_en <= reg_wdata[0];
      if (walk_fault) begin
        fault_va <= walk_fault_va;
        fault_wr <= walk_fault_wr;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tlb_inval     <= 1'b0;
      tlb_inval_vpn <= '0;
    end else begin
      tlb_inval <= we_inval;
      if (we_inval) tlb_inval_vpn <= reg_wdata[DATA_W-1:PAGE_SHIFT];
    end
  end

  logic [DATA_W-1:0] status_word, rd_mux;

  always_comb begin
    status_word        = '0;
    status_word[0]     = paging_on;
    status_word[1]     = fault_active;
    status_word[2]     = stall_on;
    status_word[3]     = walk_idle;
    status_word[4]     = replay_empty;
    status_word[5]     = fault_wr;
    status_word[DATA_W-1] = !stall_on;
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr)
      ADDR_W'(OFF_DIR):   rd_mux = dir_base;
      ADDR_W'(OFF_STAT):  rd_mux = status_word;
      ADDR_W'(OFF_FVA):   rd_mux = fault_va;
      ADDR_W'(OFF_RAW):   rd_mux = DATA_W'(raw);
      ADDR_W'(OFF_MASK):  rd_mux = DATA_W'(mask);
      ADDR_W'(OFF_MSK_S): rd_mux = DATA_W'(masked);
      ADDR_W'(OFF_GATE):  rd_mux = DATA_W'(clk_gate_en);
      default:            rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n)     reg_rdata <= '0;
    else if (rd_en) reg_rdata <= rd_mux;
  end

  assign xlate_en   = paging_on;
  assign xlate_hold = stall_on;

  // R1
  base_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_dir |=> (dir_base[DATA_W-1:PAGE_SHIFT] == $past(reg_wdata[DATA_W-1:PAGE_SHIFT])
                && dir_base[PAGE_SHIFT-1:0] == '0));

  // R11
  force_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    force_rst |=> (dir_base == '0 && !xlate_en && !xlate_hold && !irq && !clk_gate_en));

  // R6
  inval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we_inval |=> (tlb_inval && tlb_inval_vpn == $past(reg_wdata[DATA_W-1:PAGE_SHIFT])));

  logic [VPN_W-1:0] unused_vpn_w;
  assign unused_vpn_w = '0;

endmodule

// File: tb/mmu_ctl_regs_tb.sv
module mmu_ctl_regs_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_valid = 1'b0, reg_write = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        walk_fault = 1'b0, walk_fault_wr = 1'b0, walk_bus_err = 1'b0;
  logic [31:0] walk_fault_va = '0;
  logic        walk_idle = 1'b1, replay_empty = 1'b0;
  logic        xlate_en, xlate_hold, tlb_flush_all, tlb_inval, clk_gate_en, irq;
  logic [31:0] dir_base;
  logic [19:0] tlb_inval_vpn;

  int checks = 0, errors = 0;
  logic [1:0] m_raw, m_mask;
  logic        s_flush, s_inval;
  logic [19:0] s_vpn;
  logic [31:0] rv;

  always #5 clk = ~clk;

  mmu_ctl_regs dut_i (
    .clk(clk), .rst_n(rst_n), .reg_valid(reg_valid), .reg_write(reg_write),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .walk_fault(walk_fault), .walk_fault_wr(walk_fault_wr),
    .walk_fault_va(walk_fault_va), .walk_bus_err(walk_bus_err),
    .walk_idle(walk_idle), .replay_empty(replay_empty),
    .xlate_en(xlate_en), .xlate_hold(xlate_hold), .dir_base(dir_base),
    .tlb_flush_all(tlb_flush_all), .tlb_inval(tlb_inval),
    .tlb_inval_vpn(tlb_inval_vpn), .clk_gate_en(clk_gate_en), .irq(irq)
  );

  function automatic logic [31:0] exp_base(input logic [31:0] w);
    return {w[31:12], 12'h000};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk); #1;
    s_flush = tlb_flush_all; s_inval = tlb_inval; s_vpn = tlb_inval_vpn;
    reg_valid = 1'b0; reg_write = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    @(posedge clk); #1;
    d = reg_rdata;
    reg_valid = 1'b0;
  endtask

  task automatic evt(input logic f, input logic b, input logic fw, input logic [31:0] va);
    @(negedge clk);
    walk_fault = f; walk_bus_err = b; walk_fault_wr = fw; walk_fault_va = va;
    @(posedge clk); #1;
    walk_fault = 1'b0; walk_bus_err = 1'b0;
  endtask

  initial begin : watchdog
    #1500000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // Reset state
    rd(8'h04, rv); chk("R2 reset status", rv, 32'h8000_0008);
    chk("R9 reset irq", {31'd0, irq}, 32'd0);

    // R1 base alignment
    wr(8'h00, 32'hCAFE_BABE);
    rd(8'h00, rv); chk("R1 base readback", rv, exp_base(32'hCAFE_BABE));
    chk("R1 base port", dir_base, 32'hCAFE_B000);

    // R3 stall ignored while translation off
    wr(8'h08, 32'd2);
    rd(8'h04, rv); chk("R3 stall ignored", rv[2], 1'b0);
    chk("R3 hold port low", {31'd0, xlate_hold}, 32'd0);

    // R2 enable translation
    wr(8'h08, 32'd0);
    rd(8'h04, rv); chk("R2 paging on", rv[0], 1'b1);
    chk("R2 xlate_en", {31'd0, xlate_en}, 32'd1);

    // R3 stall accepted
    wr(8'h08, 32'd2);
    rd(8'h04, rv); chk("R3 stall bit", {rv[31], rv[2]}, 2'b01);
    chk("R3 hold port", {31'd0, xlate_hold}, 32'd1);

    // R4 stall exit keeps paging
    wr(8'h08, 32'd3);
    rd(8'h04, rv); chk("R4 stall off paging on", {rv[31], rv[2], rv[0]}, 3'b101);

    // R2 disable
    wr(8'h08, 32'd1);
    chk("R2 xlate off", {31'd0, xlate_en}, 32'd0);

    // R5 flush pulse
    wr(8'h08, 32'd4);
    chk("R5 flush high", {31'd0, s_flush}, 32'd1);
    @(posedge clk); #1;
    chk("R5 flush one cycle", {31'd0, tlb_flush_all}, 32'd0);

    // R6 invalidate line
    wr(8'h10, 32'h1234_5678);
    chk("R6 inval pulse", {31'd0, s_inval}, 32'd1);
    chk("R6 inval vpn", {12'd0, s_vpn}, 32'h0001_2345);
    @(posedge clk); #1;
    chk("R6 inval one cycle", {31'd0, tlb_inval}, 32'd0);

    // R12 zero reads and inputs
    rd(8'h08, rv); chk("R12 cmd reads zero", rv, 32'd0);
    rd(8'h10, rv); chk("R12 inval reads zero", rv, 32'd0);
    rd(8'h3C, rv); chk("R12 unmapped zero", rv, 32'd0);
    walk_idle = 1'b0; replay_empty = 1'b1;
    rd(8'h04, rv); chk("R12 idle/replay bits", {30'd0, rv[4:3]}, 32'd2);
    walk_idle = 1'b1;
    wr(8'h24, 32'd1); chk("R12 gate port", {31'd0, clk_gate_en}, 32'd1);

    // R7 fault capture and completion
    wr(8'h1C, 32'd3);
    evt(1'b1, 1'b0, 1'b1, 32'hDEAD_0ABC);
    rd(8'h0C, rv); chk("R7 fault va", rv, 32'hDEAD_0ABC);
    rd(8'h04, rv); chk("R7 fault status", {30'd0, rv[5], rv[1]}, 32'd3);
    rd(8'h14, rv); chk("R7 raw bit0", rv, 32'd1);
    chk("R9 irq on fault", {31'd0, irq}, 32'd1);
    wr(8'h08, 32'd5);
    rd(8'h04, rv); chk("R7 fault done", rv[1], 1'b0);

    // R8 bus error; R10 partial clear
    evt(1'b0, 1'b1, 1'b0, 32'd0);
    rd(8'h14, rv); chk("R8 raw both", rv, 32'd3);
    wr(8'h18, 32'd1);
    rd(8'h14, rv); chk("R10 clear bit0 only", rv, 32'd2);
    wr(8'h18, 32'd2);
    rd(8'h14, rv); chk("R10 clear bit1", rv, 32'd0);

    // R9/R10 random mix
    m_raw = 2'b00; m_mask = 2'b11;
    for (int i = 0; i < 300; i++) begin
      int op;
      logic [1:0] v;
      op = $urandom_range(0, 2);
      v  = 2'($urandom());
      if (op == 0) begin wr(8'h1C, {30'd0, v}); m_mask = v; end
      else if (op == 1) begin evt(v[0], v[1], 1'b0, 32'h1000); m_raw = m_raw | v; end
      else begin wr(8'h18, {30'd0, v}); m_raw = m_raw & ~v; end
      rd(8'h20, rv); chk("R9 masked status", rv, {30'd0, m_raw & m_mask});
      chk("R9 irq", {31'd0, irq}, {31'd0, |(m_raw & m_mask)});
      rd(8'h14, rv); chk("R10 raw model", rv, {30'd0, m_raw});
    end

    // R11 force reset
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h08, 32'd0);
    wr(8'h08, 32'd2);
    wr(8'h1C, 32'd3);
    evt(1'b1, 1'b1, 1'b1, 32'h5555_5000);
    wr(8'h08, 32'd6);
    rd(8'h00, rv); chk("R11 base zero", rv, 32'd0);
    rd(8'h04, rv); chk("R11 status", rv & 32'hFFFF_FFE7, 32'h8000_0000);
    rd(8'h1C, rv); chk("R11 mask zero", rv, 32'd0);
    rd(8'h14, rv); chk("R11 raw zero", rv, 32'd0);
    rd(8'h0C, rv); chk("R11 fault va zero", rv, 32'd0);
    chk("R11 ports", {28'd0, xlate_en, xlate_hold, irq, clk_gate_en}, 32'd0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule